// File: doc/BRIEF.md
# Keyed-Service Watchdog with Sticky Register Locks

This block is an 8-bit down-counting watchdog that sits behind a small register write/read bus. It counts rising edges of one of two tick inputs, which come from an external timer: the timer's output or the timer's input. Software must keep the counter from running out by servicing it. The block raises a one-cycle error pulse that the system uses as a reset request.

There are two ways to service the watchdog. In the first, software writes a fresh reload value to the count register. In the second, software writes a fixed key to a dedicated key register, which reloads the counter from the stored count. The block reports three kinds of fault as an error:

- servicing too late, meaning the counter underflows;
- servicing too often, meaning two loads arrive with no tick between them;
- writing a wrong key while key servicing is selected.

A configuration register selects the tick source and the service style. It also holds lock bits, and once a lock bit is set it stays set until reset. One lock bit protects the configuration register itself. Another protects the count register. Three more are stored for the external prescaler, timer and timer-control registers.

A mode input tells the block whether the system is active or in a low-power state. In a low-power state only the key register can be reached.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is stopped, `wd_err` is 0 and every register reads 0; all lock bits are clear.
- R2: The watchdog starts on the first accepted write to the count register (address 1) or the key register (address 2). The starting write never raises an error. Before that, ticks have no effect and no error is produced.
- R3: Once started, the watchdog keeps running until reset; no register write stops it.
- R4: Configuration bit 0 picks the tick source: 0 selects `tick_tmr_out`, 1 selects `tick_tmr_in`. Only a rising edge of the selected input is a tick, and the other input is ignored.
- R5: Each tick decrements the counter. A tick that arrives while the counter is 0 is a late-service error. After a load of N, the error therefore appears on the (N+1)th tick, and the counter reloads from the stored count.
- R6: With configuration bit 1 clear (direct mode), a count-register write while running is a service: the value is stored and loaded into the counter.
- R7: With configuration bit 1 set (key mode), writing 8'h5C to the key register while running reloads the counter from the stored count. In this mode a count-register write only stores the value.
- R8: In key mode, a key-register write of any value other than 8'h5C while running is an error, and the counter reloads from the stored count.
- R9: A service that arrives when no tick has occurred since the last load (start, service or error reload) is an error, and the reload still takes place. A tick in the same cycle as the service counts as having occurred.
- R10: An error shows as `wd_err` high for exactly one clock, in the cycle after the event.
- R11: Configuration bits 2..6 are locks, and each stays set until reset. Bit 2 locks the configuration register, bit 6 locks the count register, and bits 3..5 are kept for the external prescaler, timer and timer-control registers. A locked register ignores writes and reads as 0.
- R12: While `active_mode` is 0, writes to the configuration and count registers are ignored and those registers read as 0. Key-register writes still work.
- R13: `bus_rdata` is registered, so it shows the register selected by `bus_addr` one clock later. Address 0 is the configuration register and address 1 is the count register. Address 2 (the key register, which is write-only) and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_tmr_out | input | 1 | Tick source 0 (timer output level) |
| tick_tmr_in | input | 1 | Tick source 1 (timer input level) |
| active_mode | input | 1 | 1 = active mode, 0 = power-save or idle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| wd_err | output | 1 | One-cycle watchdog error pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit count and key 8'h5C. It programs small reload values (1 to 4), so each underflow is only a few ticks away. That makes late, early and wrong-key errors, and their reloads, quick to reach and to follow one after another. Because the default width is used, the lock and mode bit positions and the key compare are checked at their real sizes. A mid-run reset shows that the sticky locks and the running state clear.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam int KW_AW = 2;
  localparam logic [KW_AW-1:0] KW_A_CFG = 2'd0;
  localparam logic [KW_AW-1:0] KW_A_CNT = 2'd1;
  localparam logic [KW_AW-1:0] KW_A_KEY = 2'd2;

  // bit 0 = src_sel, bit 1 = key_mode, bits 2..6 = lock bits
  typedef struct packed {
    logic lk_cnt;
    logic lk_tctl;
    logic lk_tmr;
    logic lk_pre;
    logic lk_cfg;
    logic key_mode;
    logic src_sel;
  } kw_cfg_t;

  localparam int KW_CFG_W = $bits(kw_cfg_t);
  localparam int KW_LOCK_N = 5;
endpackage

// File: rtl/kw_tick_edge.sv
module kw_tick_edge #(
  parameter int N_SRC = 2,
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SW-1:0]    sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] rise;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= src_i[g];
    end
    assign rise[g] = src_i[g] & ~prev_q[g];
  end

  assign tick_o = rise[sel_i];

  // R4: a tick only follows a low level of the chosen source
  p_tick_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !$past(rst)) |-> !$past(src_i[sel_i]) || $past(sel_i) != sel_i);
endmodule

// File: rtl/kw_regs.sv
module kw_regs
  import kw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             wr_i,
  input  logic [KW_AW-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             src_sel_o,
  output logic             key_mode_o,
  output logic [DW-1:0]    cnt_val_o,
  output logic             cnt_wr_o,
  output logic             key_wr_o,
  output logic [DW-1:0]    rdata_o
);
  kw_cfg_t cfg_q, cfg_d, wcfg;
  logic [DW-1:0] cnt_q, rd_d, rdata_q;
  logic cfg_ok, cnt_ok;
  logic [KW_LOCK_N-1:0] lock_v;

  assign cfg_ok = active_i && !cfg_q.lk_cfg;
  assign cnt_ok = active_i && !cfg_q.lk_cnt;
  assign wcfg   = kw_cfg_t'(wdata_i[KW_CFG_W-1:0]);
  assign lock_v = {cfg_q.lk_cnt, cfg_q.lk_tctl, cfg_q.lk_tmr, cfg_q.lk_pre, cfg_q.lk_cfg};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i && addr_i == KW_A_CFG && cfg_ok) begin
      cfg_d.src_sel  = wcfg.src_sel;
      cfg_d.key_mode = wcfg.key_mode;
      cfg_d.lk_cfg   = cfg_q.lk_cfg  | wcfg.lk_cfg;
      cfg_d.lk_pre   = cfg_q.lk_pre  | wcfg.lk_pre;
      cfg_d.lk_tmr   = cfg_q.lk_tmr  | wcfg.lk_tmr;
      cfg_d.lk_tctl  = cfg_q.lk_tctl | wcfg.lk_tctl;
      cfg_d.lk_cnt   = cfg_q.lk_cnt  | wcfg.lk_cnt;
    end
  end

  always_comb begin
    rd_d = '0;
    if (addr_i == KW_A_CFG && cfg_ok) rd_d = {{(DW-KW_CFG_W){1'b0}}, cfg_q};
    else if (addr_i == KW_A_CNT && cnt_ok) rd_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      rdata_q <= rd_d;
      if (cnt_wr_o) cnt_q <= wdata_i;
    end
  end

  assign cnt_wr_o   = wr_i && addr_i == KW_A_CNT && cnt_ok;
  assign key_wr_o   = wr_i && addr_i == KW_A_KEY;
  assign src_sel_o  = cfg_q.src_sel;
  assign key_mode_o = cfg_q.key_mode;
  assign cnt_val_o  = cnt_q;
  assign rdata_o    = rdata_q;

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($past(lock_v) & ~lock_v) == '0);
  p_cnt_locked_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_q.lk_cnt |=> $stable(cnt_q));
  p_cfg_locked_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_q.lk_cfg |=> $stable(cfg_q));
  p_lowpower_r12: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> $stable(cfg_q) && $stable(cnt_q));
endmodule

// File: rtl/kw_core.sv
module kw_core #(
  parameter int CW = 8,
  parameter logic [CW-1:0] KEY_VAL = 8'h5C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          key_mode_i,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          cnt_wr_i,
  input  logic          key_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic          err_o
);
  logic run_q, ticked_q, err_q;
  logic [CW-1:0] cnt_q, load_val;
  logic start, svc, bad_key, early, late, err_evt, load;

  assign start    = !run_q && (cnt_wr_i || key_wr_i);
  assign bad_key  = run_q && key_wr_i && key_mode_i && (wdata_i != KEY_VAL);
  assign svc      = run_q && ((cnt_wr_i && !key_mode_i) ||
                              (key_wr_i && key_mode_i && wdata_i == KEY_VAL));
  assign early    = svc && !(ticked_q || tick_i);
  assign late     = run_q && tick_i && cnt_q == '0 && !svc;
  assign err_evt  = bad_key || early || late;
  assign load     = start || svc || err_evt;
  assign load_val = cnt_wr_i ? wdata_i : cnt_val_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      ticked_q <= 1'b0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= err_evt;
      if (start) run_q <= 1'b1;
      if (load) begin
        cnt_q    <= load_val;
        ticked_q <= 1'b0;
      end else if (run_q && tick_i) begin
        ticked_q <= 1'b1;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign err_o = err_q;

  p_err_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(run_q));
  p_run_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(run_q));
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && cnt_q != '0 && !cnt_wr_i && !key_wr_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !cnt_wr_i && !key_wr_i) |=> $stable(cnt_q));
  p_err_reload_r10: assert property (@(posedge clk) disable iff (rst)
    (err_evt && !cnt_wr_i) |=> cnt_q == $past(cnt_val_i) && err_q);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] KEY_VAL = 8'h5C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_tmr_out,
  input  logic             tick_tmr_in,
  input  logic             active_mode,
  input  logic             bus_wr,
  input  logic [KW_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             wd_err
);
  logic src_sel, key_mode, cnt_wr, key_wr, tick;
  logic [CNT_W-1:0] cnt_val;

  kw_regs #(.DW(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .active_i(active_mode), .wr_i(bus_wr),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .src_sel_o(src_sel),
    .key_mode_o(key_mode), .cnt_val_o(cnt_val), .cnt_wr_o(cnt_wr),
    .key_wr_o(key_wr), .rdata_o(bus_rdata)
  );

  kw_tick_edge #(.N_SRC(2)) u_tick (
    .clk(clk), .rst(rst), .src_i({tick_tmr_in, tick_tmr_out}),
    .sel_i(src_sel), .tick_o(tick)
  );

  kw_core #(.CW(CNT_W), .KEY_VAL(KEY_VAL)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick), .key_mode_i(key_mode),
    .cnt_val_i(cnt_val), .cnt_wr_i(cnt_wr), .key_wr_i(key_wr),
    .wdata_i(bus_wdata), .err_o(wd_err)
  );
endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_tmr_out = 1'b0, tick_tmr_in = 1'b0, active_mode = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic wd_err;

  keyed_wdog i_keyed_wdog (
    .clk(clk), .rst(rst), .tick_tmr_out(tick_tmr_out), .tick_tmr_in(tick_tmr_in),
    .active_mode(active_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_err(wd_err)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, err_seen = 0, cyc = 0;
  bit cmp_en = 0;

  // behavioural reference model
  logic [7:0] m_cfg = 0, m_store = 0, m_cnt = 0, m_rdata = 0;
  logic m_run = 0, m_tk = 0, m_err = 0, m_pa = 0, m_pb = 0;

  always @(posedge clk) begin
    logic ea, eb, tk, cfg_ok, cnt_ok, cw, kw, km, svc, e;
    logic [7:0] rd;
    if (rst) begin
      m_cfg = 0; m_store = 0; m_cnt = 0; m_rdata = 0;
      m_run = 0; m_tk = 0; m_err = 0; m_pa = 0; m_pb = 0;
    end else begin
      ea = tick_tmr_out && !m_pa; eb = tick_tmr_in && !m_pb;
      m_pa = tick_tmr_out; m_pb = tick_tmr_in;
      tk = m_cfg[0] ? eb : ea;
      km = m_cfg[1];
      cfg_ok = active_mode && !m_cfg[2];
      cnt_ok = active_mode && !m_cfg[6];
      rd = 0;
      if (bus_addr == 0 && cfg_ok) rd = m_cfg;
      if (bus_addr == 1 && cnt_ok) rd = m_store;
      cw = bus_wr && bus_addr == 1 && cnt_ok;
      kw = bus_wr && bus_addr == 2;
      e = 0;
      if (!m_run) begin
        if (cw || kw) begin
          m_run = 1; m_cnt = cw ? bus_wdata : m_store; m_tk = 0;
        end
      end else begin
        svc = (cw && !km) || (kw && km && bus_wdata == 8'h5C);
        if (kw && km && bus_wdata != 8'h5C) e = 1;
        else if (svc && !(m_tk || tk)) e = 1;
        else if (!svc && tk && m_cnt == 0) e = 1;
        if (svc || e) begin
          m_cnt = cw ? bus_wdata : m_store; m_tk = 0;
        end else if (tk) begin
          m_tk = 1;
          if (m_cnt != 0) m_cnt = m_cnt - 1;
        end
      end
      m_err = e;
      m_rdata = rd;
      if (cw) m_store = bus_wdata;
      if (bus_wr && bus_addr == 0 && cfg_ok)
        m_cfg = {1'b0, m_cfg[6:2] | bus_wdata[6:2], bus_wdata[1:0]};
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      vectors++;
      if (wd_err !== m_err) begin
        miscompares++;
        $display("FAIL R10 wd_err actual %b expected %b at cycle %0d", wd_err, m_err, cyc);
      end
      vectors++;
      if (bus_rdata !== m_rdata) begin
        miscompares++;
        $display("FAIL R13 bus_rdata actual %h expected %h at cycle %0d", bus_rdata, m_rdata, cyc);
      end
      if (wd_err === 1'b1) err_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      miscompares++;
      $display("FAIL watchdog: cycles actual %0d expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic tick_a(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_tmr_out = 1;
      @(negedge clk); tick_tmr_out = 0;
    end
  endtask

  task automatic tick_b(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_tmr_in = 1;
      @(negedge clk); tick_tmr_in = 0;
    end
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk); bus_addr = a;
    @(negedge clk); @(posedge clk);
    vectors++;
    if (bus_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s read addr %0d actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_err(int exp, string req);
    @(negedge clk); @(posedge clk);
    vectors++;
    if (err_seen != exp) begin
      miscompares++;
      $display("FAIL %s error count actual %0d expected %0d", req, err_seen, exp);
    end
  endtask

  initial begin
    idle(3);
    cmp_en = 1;
    rst = 0;
    // R1: reset state
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1");
    rd(2, 8'h00, "R13"); rd(3, 8'h00, "R13");
    // R2: ticks before start do nothing
    tick_a(3); tick_b(2); chk_err(0, "R2");
    // R2/R5: start with 3, error on the 4th tick
    wr(1, 8'd3); chk_err(0, "R2");
    tick_a(3); chk_err(0, "R5");
    tick_a(1); chk_err(1, "R5");
    // R6: direct service
    tick_a(1); wr(1, 8'd2); chk_err(1, "R6");
    tick_a(2); chk_err(1, "R6");
    tick_a(1); chk_err(2, "R5");
    // R9: service with no tick since the reload
    wr(1, 8'd2); chk_err(3, "R9");
    tick_a(1);
    // R4: the other source is ignored, then switch sources
    tick_b(5); tick_a(1); wr(1, 8'd1); chk_err(3, "R4");
    wr(0, 8'h01);
    tick_a(5); chk_err(3, "R4");
    tick_b(1); chk_err(3, "R4");
    tick_b(1); chk_err(4, "R4");
    // R7: key mode
    wr(0, 8'h03); wr(1, 8'd4);
    tick_b(1); wr(2, 8'h5C); chk_err(4, "R7");
    tick_b(4); chk_err(4, "R7");
    tick_b(1); chk_err(5, "R7");
    // R8: wrong key
    tick_b(1); wr(2, 8'h11); chk_err(6, "R8");
    // R9: key service too soon after the reload
    wr(2, 8'h5C); chk_err(7, "R9");
    tick_b(1); wr(2, 8'h5C); chk_err(7, "R7");
    // R12: low-power mode
    active_mode = 0;
    wr(0, 8'h00); rd(0, 8'h00, "R12");
    wr(1, 8'd9); rd(1, 8'h00, "R12");
    tick_b(1); wr(2, 8'h5C); chk_err(7, "R12");
    active_mode = 1;
    rd(0, 8'h03, "R12"); rd(1, 8'h04, "R12");
    // R11: locks
    wr(0, 8'h43); rd(1, 8'h00, "R11");
    wr(1, 8'd7); rd(0, 8'h43, "R11");
    wr(0, 8'h07); rd(0, 8'h00, "R11");
    wr(0, 8'h00);
    tick_b(1); wr(2, 8'h00); chk_err(8, "R11");
    tick_b(4); chk_err(8, "R11");
    tick_b(1); chk_err(9, "R3");
    // R1: a reset mid-run clears locks and stops the watchdog
    rst = 1; idle(3); rst = 0;
    tick_a(3); tick_b(3); chk_err(9, "R1");
    rd(0, 8'h00, "R1");
    wr(0, 8'h01); rd(0, 8'h01, "R1");
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule